// File: doc/BRIEF.md
# Diagnostic Flag and Status Logic

This block turns live monitor samples into the flag and status bytes of an optical transceiver's diagnostic register map. Each time a sample strobe arrives, the block compares three measurements against programmable limits. Module temperature and received modulation margin are compared as signed values. Supply voltage is compared as an unsigned value. Temperature and supply each have an upper and a lower alarm limit and an upper and a lower warning limit. Margin has only a lower alarm limit and a lower warning limit. The results are registered into four flag bytes, two for alarms and two for warnings, with every flag at a fixed bit position.

The block also builds the status/control byte. This byte mirrors the transmit-disable pin and the signal-detect pin. It holds a host-writable soft transmit-disable bit, which is ORed with the pin to form the effective transmitter disable. It carries bits that are fixed at 0 or 1, a spare bit that is stored but has no effect, and an active-low data-ready bit. The limit words come from the register store as a byte image of MSB/LSB pairs and are reassembled inside the block. The serial bus and the analog converters sit outside this block.

Top module: `diag_flag_unit`

## Requirements
- R1: Temperature is a 16-bit two's-complement value. An upper flag sets when the sample is strictly greater than its limit, and a lower flag sets when the sample is strictly less than its limit. In both `alarm_main` and `warn_main`, bit 7 is temperature high and bit 6 is temperature low.
- R2: Supply voltage is a 16-bit unsigned value compared with the same strict rules. Bit 5 is supply high and bit 4 is supply low, in both `alarm_main` and `warn_main`.
- R3: Margin is an 8-bit two's-complement value with lower limits only. Bit 5 of `alarm_aux` sets when margin is below `mg_lo_alarm`. Bit 5 of `warn_aux` sets when margin is below `mg_lo_warn`.
- R4: Bits 3..0 of `alarm_main` and `warn_main` always read 0. All bits of `alarm_aux` and `warn_aux` except bit 5 always read 0.
- R5: Flags are recomputed only on a clock edge where `smp_valid` is 1 and appear in the following cycle. Without a strobe they hold. They are not sticky: a later in-range sample clears them. Reset clears all flags.
- R6: `thr_image` byte k occupies bits [8k+7:8k], and each 16-bit limit is MSB at the even byte and LSB at the odd byte. The temperature limits sit at bytes 0-7 and the supply limits at bytes 8-15, in the order upper alarm, lower alarm, upper warning, lower warning. Both bytes of each limit take part in the compare.
- R7: `status_byte` bit 7 equals `tx_dis_pin`. Bit 6 is the soft disable, which a `ctl_wr_en` cycle loads from `ctl_wr_data[6]` and reset clears to 0.
- R8: `tx_disable` is 1 whenever `tx_dis_pin` is 1 or the soft disable bit is 1, and 0 otherwise.
- R9: `status_byte` bit 1 is the inverse of `sig_det_pin`, so 0 means a signal is detected.
- R10: In `status_byte`, bit 4 always reads 1 and bits 5 and 2 always read 0, whatever is written. Bit 3 stores `ctl_wr_data[3]` on a write and has no effect on any other output.
- R11: `status_byte` bit 0 is 1 from reset. It goes to 0 in the cycle after the first strobed sample, or after READY_CYCLES clock edges following reset, whichever comes first, and stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_temp | input | 16 | Temperature sample, signed |
| smp_vcc | input | 16 | Supply sample, unsigned |
| smp_margin | input | 8 | Margin sample, signed |
| thr_image | input | 128 | Limit byte image (MSB/LSB pairs) |
| mg_lo_alarm | input | 8 | Margin lower alarm limit |
| mg_lo_warn | input | 8 | Margin lower warning limit |
| tx_dis_pin | input | 1 | Transmit-disable pin, 1 = disable |
| sig_det_pin | input | 1 | Signal-detect pin, 1 = signal present |
| ctl_wr_en | input | 1 | Host write strobe for the control byte |
| ctl_wr_data | input | 8 | Host write data for the control byte |
| alarm_main | output | 8 | Temperature/supply alarm flags |
| alarm_aux | output | 8 | Margin alarm flag byte |
| warn_main | output | 8 | Temperature/supply warning flags |
| warn_aux | output | 8 | Margin warning flag byte |
| status_byte | output | 8 | Status/control byte |
| tx_disable | output | 1 | Effective transmitter disable |

## Verification
Three cases are hard to reach from the ports. The first is a sample whose raw bit pattern orders one way as unsigned and the other way as signed, such as a negative temperature with its top bit set or a supply code above 0x8000. The second is a sample equal to a limit, or one that differs from it only in the low byte. The third is the data-ready timeout, which needs a run of clock edges after reset with no strobe at all. The stimulus drives these patterns directly, then runs a long stretch of mixed random samples, pin toggles and control writes against a behavioural model. Finally it resets and idles the block past a shortened timeout.

// File: rtl/diag_pkg.sv
package diag_pkg;
    parameter int BYTE_W = 8;
    parameter int TEMP_W = 16;
    parameter int VCC_W  = 16;
    parameter int MRG_W  = 8;

    localparam int LIMITS     = 4;
    localparam int TEMP_BYTES = TEMP_W / BYTE_W;
    localparam int VCC_BYTES  = VCC_W / BYTE_W;
    localparam int TEMP_BASE  = 0;
    localparam int VCC_BASE   = LIMITS * TEMP_BYTES;
    localparam int THR_BYTES  = LIMITS * (TEMP_BYTES + VCC_BYTES);

    // limit slot order inside each quantity's block of the image
    localparam int LIM_HI_ALM = 0;
    localparam int LIM_LO_ALM = 1;
    localparam int LIM_HI_WRN = 2;
    localparam int LIM_LO_WRN = 3;

    typedef struct packed {
        logic hi_alm;
        logic lo_alm;
        logic hi_wrn;
        logic lo_wrn;
    } lim_flags_t;

    typedef struct packed {
        logic tx_pin;
        logic soft_dis;
        logic rsv5;
        logic fixed_one;
        logic spare;
        logic rsv2;
        logic sd_n;
        logic ready_n;
    } status_t;

    function automatic logic [BYTE_W-1:0] main_byte(input lim_flags_t t, input lim_flags_t v,
                                                    input logic want_alarm);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[7] = want_alarm ? t.hi_alm : t.hi_wrn;
        b[6] = want_alarm ? t.lo_alm : t.lo_wrn;
        b[5] = want_alarm ? v.hi_alm : v.hi_wrn;
        b[4] = want_alarm ? v.lo_alm : v.lo_wrn;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] aux_byte(input logic lo_flag);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[5] = lo_flag;
        return b;
    endfunction
endpackage

// File: rtl/diag_thr_unpack.sv
module diag_thr_unpack
    import diag_pkg::*;
#(
    parameter int W     = 16,
    parameter int BASE  = 0,
    parameter int TOTAL = 16
) (
    input  logic [TOTAL*BYTE_W-1:0]   image,
    output logic [LIMITS-1:0][W-1:0]  words
);
    localparam int NB = W / BYTE_W;

    always_comb begin
        words = '0;
        for (int i = 0; i < LIMITS; i++) begin
            for (int j = 0; j < NB; j++) begin
                // most significant byte first
                words[i][W-1-BYTE_W*j -: BYTE_W] = image[(BASE + NB*i + j)*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/diag_cmp.sv
module diag_cmp
    import diag_pkg::*;
#(
    parameter int W         = 16,
    parameter bit IS_SIGNED = 1'b1,
    parameter bit HAS_HIGH  = 1'b1
) (
    input  logic [W-1:0]              sample,
    input  logic [LIMITS-1:0][W-1:0]  lim,
    output lim_flags_t                flags
);
    logic lo_a, lo_w, hi_a, hi_w;

    generate
        if (IS_SIGNED) begin : g_signed
            assign lo_a = $signed(sample) < $signed(lim[LIM_LO_ALM]);
            assign lo_w = $signed(sample) < $signed(lim[LIM_LO_WRN]);
            if (HAS_HIGH) begin : g_hi
                assign hi_a = $signed(sample) > $signed(lim[LIM_HI_ALM]);
                assign hi_w = $signed(sample) > $signed(lim[LIM_HI_WRN]);
            end else begin : g_nohi
                logic unused_hi;
                assign unused_hi = ^{lim[LIM_HI_ALM], lim[LIM_HI_WRN]};
                assign hi_a = 1'b0;
                assign hi_w = 1'b0;
            end
        end else begin : g_unsigned
            assign lo_a = sample < lim[LIM_LO_ALM];
            assign lo_w = sample < lim[LIM_LO_WRN];
            if (HAS_HIGH) begin : g_hi
                assign hi_a = sample > lim[LIM_HI_ALM];
                assign hi_w = sample > lim[LIM_HI_WRN];
            end else begin : g_nohi
                logic unused_hi;
                assign unused_hi = ^{lim[LIM_HI_ALM], lim[LIM_HI_WRN]};
                assign hi_a = 1'b0;
                assign hi_w = 1'b0;
            end
        end
    endgenerate

    assign flags = '{hi_alm: hi_a, lo_alm: lo_a, hi_wrn: hi_w, lo_wrn: lo_w};
endmodule

// File: rtl/diag_ctl.sv
module diag_ctl
    import diag_pkg::*;
#(
    parameter int READY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              tx_dis_pin,
    input  logic              sig_det_pin,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output status_t           status,
    output logic              tx_disable
);
    localparam int CNT_W = (READY_CYCLES > 1) ? $clog2(READY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_CYCLES - 1);

    logic             soft_q;
    logic             spare_q;
    logic             ready_n_q;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_wr;

    assign unused_wr = ^{wr_data[7], wr_data[5:4], wr_data[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q    <= 1'b0;
            spare_q   <= 1'b0;
            ready_n_q <= 1'b1;
            cnt_q     <= '0;
        end else begin
            if (wr_en) begin
                soft_q  <= wr_data[6];
                spare_q <= wr_data[3];
            end
            if (cnt_q != CNT_LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (smp_valid || (cnt_q == CNT_LAST)) begin
                ready_n_q <= 1'b0;
            end
        end
    end

    always_comb begin
        status           = '0;
        status.tx_pin    = tx_dis_pin;
        status.soft_dis  = soft_q;
        status.fixed_one = 1'b1;
        status.spare     = spare_q;
        status.sd_n      = ~sig_det_pin;
        status.ready_n   = ready_n_q;
    end

    assign tx_disable = tx_dis_pin | soft_q;
endmodule

// File: rtl/diag_flag_unit.sv
module diag_flag_unit
    import diag_pkg::*;
#(
    parameter int READY_CYCLES = 1000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        smp_valid,
    input  logic [TEMP_W-1:0]           smp_temp,
    input  logic [VCC_W-1:0]            smp_vcc,
    input  logic [MRG_W-1:0]            smp_margin,
    input  logic [THR_BYTES*BYTE_W-1:0] thr_image,
    input  logic [MRG_W-1:0]            mg_lo_alarm,
    input  logic [MRG_W-1:0]            mg_lo_warn,
    input  logic                        tx_dis_pin,
    input  logic                        sig_det_pin,
    input  logic                        ctl_wr_en,
    input  logic [BYTE_W-1:0]           ctl_wr_data,
    output logic [BYTE_W-1:0]           alarm_main,
    output logic [BYTE_W-1:0]           alarm_aux,
    output logic [BYTE_W-1:0]           warn_main,
    output logic [BYTE_W-1:0]           warn_aux,
    output logic [BYTE_W-1:0]           status_byte,
    output logic                        tx_disable
);
    logic [LIMITS-1:0][TEMP_W-1:0] temp_lim;
    logic [LIMITS-1:0][VCC_W-1:0]  vcc_lim;
    logic [LIMITS-1:0][MRG_W-1:0]  mrg_lim;
    lim_flags_t temp_d, vcc_d, mrg_d;
    lim_flags_t temp_q, vcc_q, mrg_q;
    status_t    status;
    logic       unused_mrg;

    diag_thr_unpack #(.W(TEMP_W), .BASE(TEMP_BASE), .TOTAL(THR_BYTES)) u_unpack_temp (
        .image(thr_image), .words(temp_lim)
    );
    diag_thr_unpack #(.W(VCC_W), .BASE(VCC_BASE), .TOTAL(THR_BYTES)) u_unpack_vcc (
        .image(thr_image), .words(vcc_lim)
    );

    always_comb begin
        mrg_lim             = '0;
        mrg_lim[LIM_LO_ALM] = mg_lo_alarm;
        mrg_lim[LIM_LO_WRN] = mg_lo_warn;
    end

    diag_cmp #(.W(TEMP_W), .IS_SIGNED(1'b1), .HAS_HIGH(1'b1)) u_cmp_temp (
        .sample(smp_temp), .lim(temp_lim), .flags(temp_d)
    );
    diag_cmp #(.W(VCC_W), .IS_SIGNED(1'b0), .HAS_HIGH(1'b1)) u_cmp_vcc (
        .sample(smp_vcc), .lim(vcc_lim), .flags(vcc_d)
    );
    diag_cmp #(.W(MRG_W), .IS_SIGNED(1'b1), .HAS_HIGH(1'b0)) u_cmp_mrg (
        .sample(smp_margin), .lim(mrg_lim), .flags(mrg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
            vcc_q  <= '0;
            mrg_q  <= '0;
        end else if (smp_valid) begin
            temp_q <= temp_d;
            vcc_q  <= vcc_d;
            mrg_q  <= mrg_d;
        end
    end

    assign unused_mrg = mrg_q.hi_alm ^ mrg_q.hi_wrn;

    assign alarm_main = main_byte(temp_q, vcc_q, 1'b1);
    assign warn_main  = main_byte(temp_q, vcc_q, 1'b0);
    assign alarm_aux  = aux_byte(mrg_q.lo_alm);
    assign warn_aux   = aux_byte(mrg_q.lo_wrn);

    diag_ctl #(.READY_CYCLES(READY_CYCLES)) u_ctl (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .tx_dis_pin(tx_dis_pin), .sig_det_pin(sig_det_pin),
        .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .status(status), .tx_disable(tx_disable)
    );

    assign status_byte = status;
endmodule

// File: rtl/diag_flag_unit_chk.sv
module diag_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_valid,
    input logic       tx_dis_pin,
    input logic       ctl_wr_en,
    input logic [7:0] ctl_wr_data,
    input logic [7:0] alarm_main,
    input logic [7:0] alarm_aux,
    input logic [7:0] warn_main,
    input logic [7:0] warn_aux,
    input logic [7:0] status_byte,
    input logic       tx_disable
);
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (alarm_main[3:0] == 4'h0) && (warn_main[3:0] == 4'h0) &&
        ((alarm_aux & 8'hDF) == 8'h00) && ((warn_aux & 8'hDF) == 8'h00));

    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(alarm_main) && $stable(warn_main) &&
                        $stable(alarm_aux) && $stable(warn_aux)));

    a_r7_soft_bit_written: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_en |=> (status_byte[6] == $past(ctl_wr_data[6])));

    a_r8_pin_disables: assert property (@(posedge clk) disable iff (rst)
        tx_dis_pin |-> tx_disable);

    a_r8_soft_disables: assert property (@(posedge clk) disable iff (rst)
        status_byte[6] |-> tx_disable);

    a_r10_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        status_byte[4] && !status_byte[5] && !status_byte[2]);

    a_r11_ready_stays: assert property (@(posedge clk) disable iff (rst)
        !status_byte[0] |=> !status_byte[0]);
endmodule

bind diag_flag_unit diag_flag_unit_chk u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .tx_dis_pin(tx_dis_pin),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .alarm_main(alarm_main), .alarm_aux(alarm_aux),
    .warn_main(warn_main), .warn_aux(warn_aux),
    .status_byte(status_byte), .tx_disable(tx_disable)
);

// File: tb/diag_flag_unit_bench.sv
module diag_flag_unit_bench;
    localparam int RC = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_valid = 1'b0;
    logic [15:0]  smp_temp = '0;
    logic [15:0]  smp_vcc = '0;
    logic [7:0]   smp_margin = '0;
    logic [127:0] thr_image = '0;
    logic [7:0]   mg_lo_alarm = '0;
    logic [7:0]   mg_lo_warn = '0;
    logic         tx_dis_pin = 1'b0;
    logic         sig_det_pin = 1'b0;
    logic         ctl_wr_en = 1'b0;
    logic [7:0]   ctl_wr_data = '0;
    logic [7:0]   alarm_main, alarm_aux, warn_main, warn_aux, status_byte;
    logic         tx_disable;

    int n_tests = 0;
    int n_fail  = 0;

    // limits held as integers for the model: [0]=hi alarm [1]=lo alarm [2]=hi warn [3]=lo warn
    int tlim[4];
    int vlim[4];

    // model state
    logic [7:0] m_am, m_aa, m_wm, m_wa;
    logic       m_soft, m_spare, m_rdy_n;
    int         m_edges;

    always #5 clk = ~clk;

    diag_flag_unit #(.READY_CYCLES(RC)) u_diag_flag_unit (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .smp_vcc(smp_vcc), .smp_margin(smp_margin), .thr_image(thr_image),
        .mg_lo_alarm(mg_lo_alarm), .mg_lo_warn(mg_lo_warn),
        .tx_dis_pin(tx_dis_pin), .sig_det_pin(sig_det_pin),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .alarm_main(alarm_main), .alarm_aux(alarm_aux),
        .warn_main(warn_main), .warn_aux(warn_aux),
        .status_byte(status_byte), .tx_disable(tx_disable)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_limit(input int slot_byte, input logic [15:0] w);
        thr_image[slot_byte*8 +: 8]     = w[15:8];
        thr_image[(slot_byte+1)*8 +: 8] = w[7:0];
    endtask

    task automatic model_edge();
        int ti, vi, mi;
        if (rst) begin
            m_am = 0; m_aa = 0; m_wm = 0; m_wa = 0;
            m_soft = 0; m_spare = 0; m_rdy_n = 1; m_edges = 0;
        end else begin
            if (ctl_wr_en) begin
                m_soft  = ctl_wr_data[6];
                m_spare = ctl_wr_data[3];
            end
            m_edges++;
            if (smp_valid || m_edges >= RC) m_rdy_n = 0;
            if (smp_valid) begin
                ti = $signed(smp_temp);
                vi = smp_vcc;
                mi = $signed(smp_margin);
                m_am = {ti > tlim[0], ti < tlim[1], vi > vlim[0], vi < vlim[1], 4'b0};
                m_wm = {ti > tlim[2], ti < tlim[3], vi > vlim[2], vi < vlim[3], 4'b0};
                m_aa = (mi < int'($signed(mg_lo_alarm))) ? 8'h20 : 8'h00;
                m_wa = (mi < int'($signed(mg_lo_warn)))  ? 8'h20 : 8'h00;
            end
        end
    endtask

    task automatic compare_all();
        logic [7:0] st;
        st = {tx_dis_pin, m_soft, 1'b0, 1'b1, m_spare, 1'b0, ~sig_det_pin, m_rdy_n};
        chk("R1 alarm temp bits", {6'b0, alarm_main[7:6]}, {6'b0, m_am[7:6]});
        chk("R2 alarm supply bits", {6'b0, alarm_main[5:4]}, {6'b0, m_am[5:4]});
        chk("R1 warn temp bits", {6'b0, warn_main[7:6]}, {6'b0, m_wm[7:6]});
        chk("R2 warn supply bits", {6'b0, warn_main[5:4]}, {6'b0, m_wm[5:4]});
        chk("R4 main reserved", {alarm_main[3:0], warn_main[3:0]}, 8'h00);
        chk("R3 margin alarm", alarm_aux, m_aa);
        chk("R3 margin warn", warn_aux, m_wa);
        chk("R7 status pin/soft", {6'b0, status_byte[7:6]}, {6'b0, st[7:6]});
        chk("R10 status fixed/spare", {4'b0, status_byte[5:2]}, {4'b0, st[5:2]});
        chk("R9 status signal detect", {7'b0, status_byte[1]}, {7'b0, st[1]});
        chk("R11 status ready", {7'b0, status_byte[0]}, {7'b0, st[0]});
        chk("R8 tx_disable", {7'b0, tx_disable}, {7'b0, tx_dis_pin | m_soft});
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        compare_all();
    endtask

    task automatic strobe(input logic [15:0] t, input logic [15:0] v, input logic [7:0] m);
        smp_temp = t; smp_vcc = v; smp_margin = m; smp_valid = 1'b1;
        tick();
        smp_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tlim = '{32'sh4600, -32'sh1400, 32'sh4100, -32'sh0F00};
        vlim = '{32'h8CA0, 32'h7530, 32'h88B8, 32'h7918};
        // R6: each limit is MSB at the even byte, LSB at the odd byte
        set_limit(0, 16'h4600);  set_limit(2, 16'hEC00);
        set_limit(4, 16'h4100);  set_limit(6, 16'hF100);
        set_limit(8, 16'h8CA0);  set_limit(10, 16'h7530);
        set_limit(12, 16'h88B8); set_limit(14, 16'h7918);
        mg_lo_alarm = 8'hF6;
        mg_lo_warn  = 8'h00;
        smp_temp = 16'h1900; smp_vcc = 16'h80E8; smp_margin = 8'h10;
        sig_det_pin = 1'b1;

        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R11 ready high after reset", {7'b0, status_byte[0]}, 8'h01);
        chk("R7 soft clear after reset", {7'b0, status_byte[6]}, 8'h00);

        // control byte writes
        ctl_wr_en = 1'b1; ctl_wr_data = 8'hFF; tick();
        ctl_wr_en = 1'b0;
        chk("R10 write all ones", status_byte & 8'h7C, 8'h58);
        chk("R8 soft disables", {7'b0, tx_disable}, 8'h01);
        ctl_wr_en = 1'b1; ctl_wr_data = 8'h00; tick();
        ctl_wr_en = 1'b0;
        chk("R10 write zeros", status_byte & 8'h7C, 8'h10);
        tx_dis_pin = 1'b1; sig_det_pin = 1'b0; tick();
        chk("R7 pin mirrored", {7'b0, status_byte[7]}, 8'h01);
        chk("R9 no signal reads 1", {7'b0, status_byte[1]}, 8'h01);
        tx_dis_pin = 1'b0; sig_det_pin = 1'b1; tick();
        chk("R8 both clear", {7'b0, tx_disable}, 8'h00);

        // directed samples
        strobe(16'h1900, 16'h80E8, 8'h10);
        chk("R1 in range alarm", alarm_main, 8'h00);
        chk("R11 ready after first sample", {7'b0, status_byte[0]}, 8'h00);
        strobe(16'h4600, 16'h80E8, 8'h10);
        chk("R1 equal limit no alarm", alarm_main, 8'h00);
        chk("R1 above warn", warn_main, 8'h80);
        strobe(16'h4601, 16'h80E8, 8'h10);
        chk("R6 low byte counts", alarm_main, 8'h80);
        strobe(16'hE000, 16'h80E8, 8'h10);
        chk("R1 negative temp alarm", alarm_main, 8'h40);
        chk("R1 negative temp warn", warn_main, 8'h40);
        strobe(16'h1900, 16'h9000, 8'h10);
        chk("R2 unsigned high alarm", alarm_main, 8'h20);
        chk("R5 not sticky", alarm_main & 8'hC0, 8'h00);
        strobe(16'h1900, 16'h7530, 8'h10);
        chk("R2 equal low alarm", alarm_main, 8'h00);
        chk("R2 below low warn", warn_main, 8'h10);
        strobe(16'h1900, 16'h80E8, 8'h80);
        chk("R3 margin min alarm", alarm_aux, 8'h20);
        chk("R3 margin min warn", warn_aux, 8'h20);
        strobe(16'h1900, 16'h80E8, 8'hF6);
        chk("R3 margin at alarm limit", alarm_aux, 8'h00);
        chk("R3 margin below warn", warn_aux, 8'h20);
        strobe(16'h1900, 16'h80E8, 8'h7F);
        chk("R3 margin max", {alarm_aux, warn_aux} == 16'h0 ? 8'h00 : 8'h01, 8'h00);

        // change samples without strobe
        smp_temp = 16'h7FFF; smp_vcc = 16'hFFFF; smp_margin = 8'h80;
        repeat (3) tick();
        chk("R5 held main", alarm_main, 8'h00);
        chk("R5 held aux", alarm_aux, 8'h00);

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            smp_valid   = ($urandom % 3) != 0;
            smp_temp    = ($urandom % 2) ? 16'(32'sh4600 + $signed($urandom % 5) - 2) : 16'($urandom);
            smp_vcc     = ($urandom % 2) ? 16'(32'h7530 + ($urandom % 5) - 2) : 16'($urandom);
            smp_margin  = 8'($urandom);
            tx_dis_pin  = ($urandom % 4) == 0;
            sig_det_pin = ($urandom % 2) == 0;
            ctl_wr_en   = ($urandom % 8) == 0;
            ctl_wr_data = 8'($urandom);
            tick();
        end
        smp_valid = 1'b0; ctl_wr_en = 1'b0;

        // timeout path of data ready
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        repeat (RC - 1) tick();
        chk("R11 ready still high before timeout", {7'b0, status_byte[0]}, 8'h01);
        tick();
        chk("R11 ready low at timeout", {7'b0, status_byte[0]}, 8'h00);
        repeat (3) tick();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule